// File: doc/BRIEF.md
# Accumulator ALU with Carry

This block is the 8-bit accumulator datapath of a small microcontroller core. Each request carries an operation class and a minor select, the present accumulator, one operand byte (already fetched from a register, from indirect memory or from an immediate field) and the present carry. The block returns the new accumulator, the new carry, a zero flag for conditional branches, and a memory write-back byte. That byte differs from the operand only for the low-nibble exchange.

Requests enter on a valid/ready handshake and results leave on another one, through a single output register. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being emptied in the same cycle. A result is offered with `out_valid` and stays unchanged until it is taken on an edge where `out_ready` is high. Results leave in the order the requests were accepted. Each accepted request produces its result in the next cycle. Full throughput is one request per cycle while `out_ready` stays high.

Top module: `acc_alu`

## Requirements
- R1: Class 0 minor 0 gives acc+opnd and minor 1 gives acc+opnd+carry. In both cases the new carry is the bit carried out of bit 7, and the incoming carry has no effect on plain add.
- R2: Class 1 minor 0/1/2 gives acc AND, OR or XOR opnd. Minor 3 leaves the accumulator as it is. Carry is unchanged for every class 1 operation.
- R3: Class 0 minor 2 increments and minor 3 decrements the accumulator modulo 256 (FFh gives 00h, 00h gives FFh). Class 4 minor 0 clears and minor 1 complements the accumulator. Carry is unchanged for all four operations.
- R4: Class 2 minor 0 rotates the accumulator left and minor 1 rotates it right, as an 8-bit ring. Carry is unchanged.
- R5: Class 2 minor 2 and 3 rotate left and right through carry, as a 9-bit ring. The bit shifted out of the accumulator becomes the new carry, and the old carry enters at the other end.
- R6: Class 3 minor 0 exchanges accumulator bits 3:0 with bits 7:4. Carry is unchanged.
- R7: Class 3 minor 1 puts opnd bits 3:0 into accumulator bits 3:0 and puts accumulator bits 3:0 into mem_out bits 3:0. The upper nibbles of both keep their values. For every other operation mem_out equals opnd.
- R8: Class 4 minor 2 clears carry and minor 3 inverts carry. The accumulator is left unchanged.
- R9: Class 3 minor 2 is the decimal adjust. It first adds 06h if the low digit is above 9. It then adds 60h if the high digit is above 9 or carry is set. Carry is set by an overflow out of bit 7 in either step and is never cleared.
- R10: zero_out is high exactly when the result accumulator is 00h.
- R11: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, every output holds its value. Results appear in acceptance order, one cycle after acceptance.
- R12: After reset out_valid is low and in_ready is high.
- R13: Classes 5 to 7, and class 3 minor 3, leave the accumulator and the carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| op_class | input | 3 | Operation class |
| op_minor | input | 2 | Operation within the class |
| acc_in | input | DATA_W | Present accumulator |
| opnd_in | input | DATA_W | Operand byte |
| carry_in | input | 1 | Present carry |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result can be taken this cycle |
| acc_out | output | DATA_W | New accumulator |
| carry_out | output | 1 | New carry |
| mem_out | output | DATA_W | Memory write-back byte |
| zero_out | output | 1 | New accumulator is zero |

## Verification
The bench builds the block with the default DATA_W of 8. At that width the decimal adjust works on two packed BCD digits, so both adjust steps and the overflow from either step can be reached with real BCD results. The bench drops out_ready on a pseudo-random pattern, which exercises back-pressure during back-to-back traffic. It also holds one result stalled for several cycles and checks that every output stays stable and that in_ready stays low.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [2:0] {
    CLS_ARITH = 3'd0,
    CLS_LOGIC = 3'd1,
    CLS_ROT   = 3'd2,
    CLS_NIB   = 3'd3,
    CLS_FLAG  = 3'd4
  } op_class_e;

  localparam logic [1:0] AR_ADD  = 2'd0;
  localparam logic [1:0] AR_ADDC = 2'd1;
  localparam logic [1:0] AR_INC  = 2'd2;
  localparam logic [1:0] AR_DEC  = 2'd3;

  localparam logic [1:0] LG_AND  = 2'd0;
  localparam logic [1:0] LG_OR   = 2'd1;
  localparam logic [1:0] LG_XOR  = 2'd2;

  localparam logic [1:0] RT_L    = 2'd0;
  localparam logic [1:0] RT_R    = 2'd1;
  localparam logic [1:0] RT_LC   = 2'd2;
  localparam logic [1:0] RT_RC   = 2'd3;

  localparam logic [1:0] NB_SWAP = 2'd0;
  localparam logic [1:0] NB_XLO  = 2'd1;
  localparam logic [1:0] NB_BCD  = 2'd2;

  localparam logic [1:0] FL_CLRA = 2'd0;
  localparam logic [1:0] FL_CPLA = 2'd1;
  localparam logic [1:0] FL_CLRC = 2'd2;
  localparam logic [1:0] FL_CPLC = 2'd3;

  localparam int DIGIT_W = 4;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        minor,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  import acc_alu_pkg::*;

  logic [DATA_W:0] sum;
  logic            add_cin;

  assign add_cin = (minor == AR_ADDC) ? cin : 1'b0;
  assign sum     = {1'b0, acc} + {1'b0, opnd} + {{DATA_W{1'b0}}, add_cin};

  always_comb begin
    res  = acc;
    cout = cin;
    unique case (minor)
      AR_ADD, AR_ADDC: begin
        res  = sum[DATA_W-1:0];
        cout = sum[DATA_W];
      end
      AR_INC: res = acc + 1'b1;
      AR_DEC: res = acc - 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_bcd.sv
module acc_alu_bcd #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  import acc_alu_pkg::*;

  localparam int NDIG = DATA_W / DIGIT_W;

  logic [DATA_W:0] work;
  logic            ovf;

  always_comb begin
    work = {1'b0, acc};
    ovf  = 1'b0;
    for (int d = 0; d < NDIG; d++) begin
      if ((work[d*DIGIT_W +: DIGIT_W] > 4'd9) ||
          ((d == NDIG - 1) && (cin || ovf))) begin
        work = work + ((DATA_W+1)'(6) << (d * DIGIT_W));
        if (work[DATA_W]) begin
          ovf          = 1'b1;
          work[DATA_W] = 1'b0;
        end
      end
    end
    res  = work[DATA_W-1:0];
    cout = cin | ovf;
  end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops #(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        cls,
  input  logic [1:0]        minor,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout,
  output logic [DATA_W-1:0] mem
);
  import acc_alu_pkg::*;

  localparam int HALF = DATA_W / 2;

  always_comb begin
    res  = acc;
    cout = cin;
    mem  = opnd;
    case (cls)
      CLS_LOGIC: begin
        case (minor)
          LG_AND:  res = acc & opnd;
          LG_OR:   res = acc | opnd;
          LG_XOR:  res = acc ^ opnd;
          default: ;
        endcase
      end
      CLS_ROT: begin
        case (minor)
          RT_L: res = {acc[DATA_W-2:0], acc[DATA_W-1]};
          RT_R: res = {acc[0], acc[DATA_W-1:1]};
          RT_LC: begin
            res  = {acc[DATA_W-2:0], cin};
            cout = acc[DATA_W-1];
          end
          default: begin
            res  = {cin, acc[DATA_W-1:1]};
            cout = acc[0];
          end
        endcase
      end
      CLS_NIB: begin
        case (minor)
          NB_SWAP: res = {acc[HALF-1:0], acc[DATA_W-1:HALF]};
          NB_XLO: begin
            res = {acc[DATA_W-1:DIGIT_W], opnd[DIGIT_W-1:0]};
            mem = {opnd[DATA_W-1:DIGIT_W], acc[DIGIT_W-1:0]};
          end
          default: ;
        endcase
      end
      CLS_FLAG: begin
        case (minor)
          FL_CLRA: res  = '0;
          FL_CPLA: res  = ~acc;
          FL_CLRC: cout = 1'b0;
          default: cout = ~cin;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_slot.sv
module acc_alu_slot #(
  parameter int PAY_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_pay,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_pay
);
  logic full_q;
  logic [PAY_W-1:0] pay_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_pay   = pay_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      pay_q  <= '0;
    end else if (in_ready) begin
      full_q <= in_valid;
      if (in_valid) pay_q <= in_pay;
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        op_class,
  input  logic [1:0]        op_minor,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic              carry_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] acc_out,
  output logic              carry_out,
  output logic [DATA_W-1:0] mem_out,
  output logic              zero_out
);
  import acc_alu_pkg::*;

  localparam int PAY_W = 2 * DATA_W + 2;

  logic [DATA_W-1:0] ar_res, bcd_res, bit_res, bit_mem, sel_res;
  logic              ar_c, bcd_c, bit_c, sel_c, sel_z;
  logic [PAY_W-1:0]  pay_in, pay_out;

  acc_alu_arith #(.DATA_W(DATA_W)) arith_i (
    .minor(op_minor), .acc(acc_in), .opnd(opnd_in), .cin(carry_in),
    .res(ar_res), .cout(ar_c)
  );

  acc_alu_bcd #(.DATA_W(DATA_W)) bcd_i (
    .acc(acc_in), .cin(carry_in), .res(bcd_res), .cout(bcd_c)
  );

  acc_alu_bitops #(.DATA_W(DATA_W)) bitops_i (
    .cls(op_class), .minor(op_minor), .acc(acc_in), .opnd(opnd_in),
    .cin(carry_in), .res(bit_res), .cout(bit_c), .mem(bit_mem)
  );

  always_comb begin
    if (op_class == CLS_ARITH) begin
      sel_res = ar_res;
      sel_c   = ar_c;
    end else if (op_class == CLS_NIB && op_minor == NB_BCD) begin
      sel_res = bcd_res;
      sel_c   = bcd_c;
    end else begin
      sel_res = bit_res;
      sel_c   = bit_c;
    end
  end

  assign sel_z  = (sel_res == '0);
  assign pay_in = {sel_res, sel_c, bit_mem, sel_z};

  acc_alu_slot #(.PAY_W(PAY_W)) slot_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_pay(pay_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_pay(pay_out)
  );

  assign {acc_out, carry_out, mem_out, zero_out} = pay_out;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        op_class,
  input logic [1:0]        op_minor,
  input logic [DATA_W-1:0] acc_in,
  input logic [DATA_W-1:0] opnd_in,
  input logic              carry_in,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] acc_out,
  input logic              carry_out,
  input logic [DATA_W-1:0] mem_out,
  input logic              zero_out
);
  logic take;
  assign take = in_valid && in_ready;

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(acc_out) &&
    $stable(carry_out) && $stable(mem_out) && $stable(zero_out));

  // R11
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R2
  logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && op_class == 3'd1 |=> carry_out == $past(carry_in));

  // R8
  clear_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && op_class == 3'd4 && op_minor == 2'd2 |=> !carry_out);

  // R7
  xlo_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && op_class == 3'd3 && op_minor == 2'd1 |=>
    mem_out[DATA_W-1:4] == $past(opnd_in[DATA_W-1:4]) &&
    acc_out[DATA_W-1:4] == $past(acc_in[DATA_W-1:4]));

  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> zero_out == (acc_out == '0));
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op_class(op_class), .op_minor(op_minor), .acc_in(acc_in),
  .opnd_in(opnd_in), .carry_in(carry_in), .out_valid(out_valid),
  .out_ready(out_ready), .acc_out(acc_out), .carry_out(carry_out),
  .mem_out(mem_out), .zero_out(zero_out)
);

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] op_class = '0;
  logic [1:0] op_minor = '0;
  logic [7:0] acc_in = '0, opnd_in = '0;
  logic       carry_in = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] acc_out, mem_out;
  logic       carry_out, zero_out;

  int n_checks = 0;
  int n_fail = 0;
  bit stall_hold = 1'b0;
  bit streaming = 1'b0;

  typedef struct {
    logic [7:0] acc;
    logic       c;
    logic [7:0] mem;
    logic       z;
    string      tag;
  } exp_t;

  exp_t q[$];

  always #5 clk = ~clk;

  acc_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_class(op_class), .op_minor(op_minor), .acc_in(acc_in),
    .opnd_in(opnd_in), .carry_in(carry_in), .out_valid(out_valid),
    .out_ready(out_ready), .acc_out(acc_out), .carry_out(carry_out),
    .mem_out(mem_out), .zero_out(zero_out)
  );

  function automatic exp_t model(input logic [2:0] k, input logic [1:0] m,
                                 input logic [7:0] a, input logic [7:0] o,
                                 input logic c, input string tag);
    exp_t r;
    logic [8:0] t;
    r.acc = a; r.c = c; r.mem = o; r.tag = tag;
    case (k)
      3'd0: case (m)
        2'd0: begin t = a + o; r.acc = t[7:0]; r.c = t[8]; end
        2'd1: begin t = a + o + c; r.acc = t[7:0]; r.c = t[8]; end
        2'd2: r.acc = (a == 8'hFF) ? 8'h00 : a + 8'd1;
        default: r.acc = (a == 8'h00) ? 8'hFF : a - 8'd1;
      endcase
      3'd1: case (m)
        2'd0: r.acc = a & o;
        2'd1: r.acc = a | o;
        2'd2: r.acc = a ^ o;
        default: ;
      endcase
      3'd2: case (m)
        2'd0: r.acc = (a << 1) | (a >> 7);
        2'd1: r.acc = (a >> 1) | (a << 7);
        2'd2: begin r.acc = (a << 1) | {7'd0, c}; r.c = a[7]; end
        default: begin r.acc = (a >> 1) | {c, 7'd0}; r.c = a[0]; end
      endcase
      3'd3: case (m)
        2'd0: r.acc = {a[3:0], a[7:4]};
        2'd1: begin r.acc = (a & 8'hF0) | (o & 8'h0F); r.mem = (o & 8'hF0) | (a & 8'h0F); end
        2'd2: begin
          t = {1'b0, a};
          if (t[3:0] > 4'd9) t = t + 9'h006;
          if (t[8]) r.c = 1'b1;
          t[8] = 1'b0;
          if (t[7:4] > 4'd9 || r.c) t = t + 9'h060;
          if (t[8]) r.c = 1'b1;
          r.acc = t[7:0];
        end
        default: ;
      endcase
      3'd4: case (m)
        2'd0: r.acc = 8'h00;
        2'd1: r.acc = ~a;
        2'd2: r.c = 1'b0;
        default: r.c = ~c;
      endcase
      default: ;
    endcase
    r.z = (r.acc == 8'h00);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [1:0] m,
                      input logic [7:0] a, input logic [7:0] o,
                      input logic c, input string tag);
    q.push_back(model(k, m, a, o, c, tag));
    op_class = k; op_minor = m; acc_in = a; opnd_in = o; carry_in = c;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // monitor: a transfer happens on the next edge when both are high at negedge
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R11", "unexpected result", acc_out, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(acc_out == e.acc && carry_out == e.c && mem_out == e.mem &&
              zero_out == e.z, e.tag, "acc/c/mem/z",
              {acc_out, carry_out, mem_out, zero_out},
              {e.acc, e.c, e.mem, e.z});
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (stall_hold) out_ready = 1'b0;
    else if (streaming) out_ready = ($urandom % 4) != 0;
    else out_ready = 1'b1;
  end

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", "timeout", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check(out_valid == 1'b0, "R12", "out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R12", "in_ready", in_ready, 1);
    rst_n = 1'b1;
    streaming = 1'b1;
    @(posedge clk); #1;

    send(3'd0, 2'd0, 8'h3C, 8'h44, 1'b1, "R1 add ignores carry");
    send(3'd0, 2'd0, 8'hFF, 8'h01, 1'b0, "R1 add overflow");
    send(3'd0, 2'd1, 8'h7F, 8'h00, 1'b1, "R1 addc");
    send(3'd0, 2'd1, 8'hFF, 8'hFF, 1'b1, "R1 addc max");
    send(3'd1, 2'd0, 8'hF0, 8'h3C, 1'b1, "R2 and");
    send(3'd1, 2'd1, 8'h81, 8'h18, 1'b0, "R2 or");
    send(3'd1, 2'd2, 8'h5A, 8'h5A, 1'b1, "R2 xor zero");
    send(3'd1, 2'd3, 8'h66, 8'h11, 1'b1, "R2 pass");
    send(3'd0, 2'd2, 8'hFF, 8'h00, 1'b0, "R3 inc wrap");
    send(3'd0, 2'd3, 8'h00, 8'h00, 1'b1, "R3 dec wrap");
    send(3'd4, 2'd0, 8'hA7, 8'h00, 1'b1, "R3 clr acc");
    send(3'd4, 2'd1, 8'h5A, 8'h00, 1'b0, "R3 cpl acc");
    send(3'd2, 2'd0, 8'h81, 8'h00, 1'b0, "R4 rotate left");
    send(3'd2, 2'd1, 8'h81, 8'h00, 1'b1, "R4 rotate right");
    send(3'd2, 2'd2, 8'h80, 8'h00, 1'b0, "R5 rlc out");
    send(3'd2, 2'd2, 8'h01, 8'h00, 1'b1, "R5 rlc in");
    send(3'd2, 2'd3, 8'h01, 8'h00, 1'b1, "R5 rrc both");
    send(3'd2, 2'd3, 8'h02, 8'h00, 1'b1, "R5 rrc in");
    send(3'd3, 2'd0, 8'h3C, 8'h00, 1'b1, "R6 swap");
    send(3'd3, 2'd1, 8'h12, 8'hAB, 1'b0, "R7 low exchange");
    send(3'd3, 2'd1, 8'hF0, 8'h0F, 1'b1, "R7 low exchange zero");
    send(3'd4, 2'd2, 8'h33, 8'h44, 1'b1, "R8 clear carry");
    send(3'd4, 2'd3, 8'h33, 8'h44, 1'b0, "R8 cpl carry");
    send(3'd4, 2'd3, 8'h00, 8'h44, 1'b1, "R8 cpl carry off");
    send(3'd3, 2'd2, 8'h9A, 8'h00, 1'b0, "R9 da both digits");
    send(3'd3, 2'd2, 8'h15, 8'h00, 1'b1, "R9 da carry in");
    send(3'd3, 2'd2, 8'h3C, 8'h00, 1'b0, "R9 da low digit");
    send(3'd3, 2'd2, 8'hFA, 8'h00, 1'b0, "R9 da low step overflow");
    send(3'd3, 2'd2, 8'h45, 8'h00, 1'b0, "R9 da no change");
    send(3'd0, 2'd0, 8'h00, 8'h00, 1'b0, "R10 zero add");
    send(3'd5, 2'd1, 8'hC3, 8'h11, 1'b1, "R13 class 5");
    send(3'd6, 2'd2, 8'h00, 8'h22, 1'b0, "R13 class 6");
    send(3'd7, 2'd3, 8'h7E, 8'h33, 1'b1, "R13 class 7");
    send(3'd3, 2'd3, 8'h5D, 8'h44, 1'b0, "R13 nibble reserved");
    for (int i = 0; i < 40; i++)
      send(3'd0, 2'd1, 8'(i * 37), 8'(i * 11), 1'(i), "R11 stream addc");

    while (q.size() != 0 || out_valid) @(negedge clk);
    streaming = 1'b0;
    stall_hold = 1'b1;
    @(posedge clk); #2;
    send(3'd3, 2'd0, 8'hA5, 8'h00, 1'b0, "R11 after stall");
    repeat (3) @(negedge clk);
    check(out_valid == 1'b1, "R11", "stall valid", out_valid, 1);
    check(in_ready == 1'b0, "R11", "stall in_ready", in_ready, 0);
    check(acc_out == 8'h5A, "R11", "stall acc", acc_out, 8'h5A);
    @(negedge clk);
    check(acc_out == 8'h5A && out_valid, "R11", "stall hold", acc_out, 8'h5A);
    stall_hold = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(q.size() == 0, "R11", "queue drained", q.size(), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule